// File: doc/BRIEF.md
# Video Frame Stream Cleaner

This block sits inline on a packetized video stream and makes sure every frame's pixel packet is exactly as long as the control packet in front of it says it should be. Each beat carries four pixels, with three 10-bit colour symbols per pixel. Both ports use valid/ready handshaking with start-of-packet and end-of-packet markers. The first beat of every packet is a header beat, and its low four bits give the packet type.

A control packet gives the frame width and height. The block forwards it unchanged and records the pixel-packet length it implies. When the next pixel packet arrives, the block counts its data beats. If the packet ends early, the block holds off the input and appends mid-grey beats until the count is reached. If the packet runs long, the block marks the expected last beat as end-of-packet and silently swallows the rest. A pixel packet with no fresh control packet in front of it is dropped whole. The block adds no latency: every forwarded beat passes through combinationally, under the downstream ready.

Top module: `svc_stream_cleaner`

## Requirements
- R1: After reset the output is idle: out_valid is low until a packet is presented.
- R2: A packet whose header beat has type code 4'hF (control) or any code other than 4'h0 is forwarded beat for beat, unchanged, with its start and end markers.
- R3: In a control packet, the beat after the header holds the width in bits [15:0] and the height in bits [31:16]. The following pixel packet must carry ceil(width*height/4) data beats after its header.
- R4: A pixel packet (header type 4'h0) with exactly the expected number of data beats is forwarded unchanged.
- R5: A pixel packet that ends early has end-of-packet removed from its last real beat. It is then followed by grey beats, in which all twelve symbols equal 512, up to the expected count. Only the final grey beat carries end-of-packet.
- R6: Grey beats advance only on a downstream handshake, and in_ready stays low while they are being emitted.
- R7: In a pixel packet that runs long, data beat number ceil(width*height/4) carries end-of-packet. All later beats of that packet are accepted and discarded.
- R8: A pixel packet with no control packet since the previous pixel packet is accepted and dropped entirely: nothing is output. Each control packet arms only one pixel packet.
- R9: A control packet with zero width or zero height arms nothing, so the pixel packet that follows it is dropped.
- R10: While out_valid is high and out_ready is low, the output beat, its markers and out_valid are held.
- R11: A pixel packet consisting of only its header, with end-of-packet on the header, is completed entirely with grey beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_data | input | 120 | Input beat: 4 pixels x 3 symbols x 10 bits; header type in [3:0] |
| in_valid | input | 1 | Input beat valid |
| in_sop | input | 1 | Input start of packet |
| in_eop | input | 1 | Input end of packet |
| in_ready | output | 1 | Block accepts the input beat |
| out_data | output | 120 | Output beat |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet |
| out_ready | input | 1 | Downstream accepts the output beat |

## Verification
The bench targets the following corner cases:
- **Frame sizes that are not a multiple of four pixels.** A wrong rounding of the expected count would pad or trim by one beat.
- **Packets one beat short and several beats long.** A block that kept the original end marker would emit a second packet end, or forward trailing garbage into the next frame.
- **Header-only pixel packets, pixel packets with no control packet, and zero-sized control packets.** A block that reused a stale size would output a phantom frame.
- **Random downstream stalls in the middle of padding.** A block that let padding advance without a handshake, or accepted input during padding, would lose grey beats or lose the next packet's header.

// File: rtl/svc_pkg.sv
package svc_pkg;

  localparam int TYPE_W = 4;
  localparam logic [TYPE_W-1:0] PKT_PIXEL = 4'h0;
  localparam logic [TYPE_W-1:0] PKT_CTRL  = 4'hF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_PIX,
    ST_PAD,
    ST_TRIM,
    ST_DROP
  } svc_state_e;

endpackage

// File: rtl/svc_rst_sync.sv
module svc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/svc_ctrl_snoop.sv
// Watches control packets and keeps the pixel-packet length they announce.
module svc_ctrl_snoop #(
  parameter int DIM_W = 16,
  parameter int PPB   = 4,
  parameter int CNT_W = 2 * DIM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_acc,
  input  logic             hdr_ctrl,
  input  logic             consume,
  input  logic [DIM_W-1:0] dim_w,
  input  logic [DIM_W-1:0] dim_h,
  output logic             armed,
  output logic [CNT_W-1:0] exp_beats
);
  localparam int PROD_W = 2 * DIM_W;
  localparam int SUM_W  = PROD_W + 1;

  logic             want_q, want_d;
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] exp_q, exp_d;
  logic [PROD_W-1:0] prod;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  beats;

  always_comb begin
    prod  = PROD_W'(dim_w) * PROD_W'(dim_h);
    sum   = {1'b0, prod} + SUM_W'(PPB - 1);
    beats = sum / SUM_W'(PPB);
  end

  always_comb begin
    want_d  = want_q;
    armed_d = armed_q;
    exp_d   = exp_q;
    if (hdr_ctrl) begin
      want_d = 1'b1;
    end else if (want_q && beat_acc) begin
      want_d  = 1'b0;
      exp_d   = beats[CNT_W-1:0];
      armed_d = (dim_w != '0) && (dim_h != '0);
    end
    if (consume) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q  <= 1'b0;
      armed_q <= 1'b0;
      exp_q   <= '0;
    end else begin
      want_q  <= want_d;
      armed_q <= armed_d;
      exp_q   <= exp_d;
    end
  end

  assign armed     = armed_q;
  assign exp_beats = exp_q;
endmodule

// File: rtl/svc_beat_track.sv
// Counts data beats of the current pixel packet against the expected length.
module svc_beat_track #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] exp_in,
  input  logic             step,
  output logic             last,
  output logic [CNT_W-1:0] exp_out
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] exp_q, exp_d;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (load) begin
      cnt_d = '0;
      exp_d = exp_in;
    end else if (step) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign last    = (cnt_q + CNT_W'(1)) == exp_q;
  assign exp_out = exp_q;
endmodule

// File: rtl/svc_grey_beat.sv
module svc_grey_beat #(
  parameter int PPB   = 4,
  parameter int SPP   = 3,
  parameter int SYM_W = 10
) (
  output logic [PPB*SPP*SYM_W-1:0] beat
);
  localparam int NSYM = PPB * SPP;
  localparam logic [SYM_W-1:0] MID = SYM_W'(1) << (SYM_W - 1);

  for (genvar g = 0; g < NSYM; g++) begin : g_sym
    assign beat[g*SYM_W +: SYM_W] = MID;
  end
endmodule

// File: rtl/svc_stream_cleaner.sv
module svc_stream_cleaner #(
  parameter int PPB   = 4,
  parameter int SPP   = 3,
  parameter int SYM_W = 10,
  parameter int DIM_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PPB*SPP*SYM_W-1:0] in_data,
  input  logic                     in_valid,
  input  logic                     in_sop,
  input  logic                     in_eop,
  output logic                     in_ready,
  output logic [PPB*SPP*SYM_W-1:0] out_data,
  output logic                     out_valid,
  output logic                     out_sop,
  output logic                     out_eop,
  input  logic                     out_ready
);
  import svc_pkg::*;

  localparam int DATA_W = PPB * SPP * SYM_W;
  localparam int CNT_W  = 2 * DIM_W;

  logic              rst_sync_n;
  svc_state_e        st_q, st_d;
  logic              armed;
  logic [CNT_W-1:0]  snoop_exp;
  logic [CNT_W-1:0]  trk_exp;
  logic              trk_last;
  logic              consume, load, step, hdr_ctrl;
  logic [DATA_W-1:0] grey;
  logic [TYPE_W-1:0] pkt_type;

  assign pkt_type = in_data[TYPE_W-1:0];

  svc_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  svc_ctrl_snoop #(.DIM_W(DIM_W), .PPB(PPB), .CNT_W(CNT_W)) i_snoop (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .beat_acc  (in_valid && in_ready),
    .hdr_ctrl  (hdr_ctrl),
    .consume   (consume),
    .dim_w     (in_data[DIM_W-1:0]),
    .dim_h     (in_data[2*DIM_W-1:DIM_W]),
    .armed     (armed),
    .exp_beats (snoop_exp)
  );

  svc_beat_track #(.CNT_W(CNT_W)) i_track (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (load),
    .exp_in  (snoop_exp),
    .step    (step),
    .last    (trk_last),
    .exp_out (trk_exp)
  );

  svc_grey_beat #(.PPB(PPB), .SPP(SPP), .SYM_W(SYM_W)) i_grey (
    .beat (grey)
  );

  always_comb begin
    st_d      = st_q;
    out_valid = 1'b0;
    out_data  = in_data;
    out_sop   = in_sop;
    out_eop   = in_eop;
    in_ready  = 1'b1;
    consume   = 1'b0;
    load      = 1'b0;
    step      = 1'b0;
    hdr_ctrl  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (in_valid && in_sop) begin
          if (pkt_type == PKT_PIXEL) begin
            if (armed) begin
              out_valid = 1'b1;
              out_eop   = 1'b0;
              in_ready  = out_ready;
              if (out_ready) begin
                consume = 1'b1;
                load    = 1'b1;
                st_d    = in_eop ? ST_PAD : ST_PIX;
              end
            end else if (!in_eop) begin
              st_d = ST_DROP;
            end
          end else begin
            out_valid = 1'b1;
            in_ready  = out_ready;
            if (out_ready && !in_eop) begin
              hdr_ctrl = (pkt_type == PKT_CTRL);
              st_d     = ST_PASS;
            end
          end
        end
      end
      ST_PASS: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        if (in_valid && out_ready && in_eop) st_d = ST_IDLE;
      end
      ST_PIX: begin
        out_valid = in_valid;
        out_sop   = 1'b0;
        out_eop   = trk_last;
        in_ready  = out_ready;
        if (in_valid && out_ready) begin
          step = 1'b1;
          if (trk_last)    st_d = in_eop ? ST_IDLE : ST_TRIM;
          else if (in_eop) st_d = ST_PAD;
        end
      end
      ST_PAD: begin
        out_valid = 1'b1;
        out_data  = grey;
        out_sop   = 1'b0;
        out_eop   = trk_last;
        in_ready  = 1'b0;
        if (out_ready) begin
          step = 1'b1;
          if (trk_last) st_d = ST_IDLE;
        end
      end
      ST_TRIM, ST_DROP: begin
        if (in_valid && in_eop) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st_q <= ST_IDLE;
    else             st_q <= st_d;
  end
endmodule

// File: rtl/svc_stream_cleaner_chk.sv
module svc_stream_cleaner_chk #(
  parameter int PPB   = 4,
  parameter int SPP   = 3,
  parameter int SYM_W = 10,
  parameter int CNT_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [3:0]               in_type,
  input logic                     in_valid,
  input logic                     in_sop,
  input logic                     in_ready,
  input logic [PPB*SPP*SYM_W-1:0] out_data,
  input logic                     out_valid,
  input logic                     out_sop,
  input logic                     out_eop,
  input logic                     out_ready,
  input logic                     idle,
  input logic                     armed,
  input logic [CNT_W-1:0]         exp_beats
);
  localparam logic [SYM_W-1:0] MID = SYM_W'(1) << (SYM_W - 1);
  localparam logic [PPB*SPP*SYM_W-1:0] GREY = {(PPB*SPP){MID}};

  logic             open_q, pix_q;
  logic [CNT_W-1:0] cnt_q;
  logic             out_hs;

  assign out_hs = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      pix_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (out_hs) begin
      open_q <= !out_eop;
      if (out_sop) begin
        pix_q <= (out_data[3:0] == 4'h0) && !out_eop;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (out_eop) pix_q <= 1'b0;
      end
    end
  end

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

  assert_pad_is_grey_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hs && !in_ready) |-> (out_data == GREY && !out_sop));

  assert_drop_unarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && in_valid && in_sop && in_type == 4'h0 && !armed) |-> (!out_valid && in_ready));

  assert_frame_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hs && out_eop && !out_sop && pix_q) |-> ((cnt_q + CNT_W'(1)) == exp_beats));

  assert_no_nested_sop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_hs && out_sop) |-> !open_q);
endmodule

bind svc_stream_cleaner svc_stream_cleaner_chk #(
  .PPB(PPB), .SPP(SPP), .SYM_W(SYM_W), .CNT_W(2*DIM_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_type   (in_data[3:0]),
  .in_valid  (in_valid),
  .in_sop    (in_sop),
  .in_ready  (in_ready),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .out_ready (out_ready),
  .idle      (st_q == svc_pkg::ST_IDLE),
  .armed     (armed),
  .exp_beats (trk_exp)
);

// File: tb/test_svc_stream_cleaner.sv
`timescale 1ns/1ps
module test_svc_stream_cleaner;
  localparam int DW = 120;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] in_data, out_data;
  logic          in_valid, in_sop, in_eop, in_ready;
  logic          out_valid, out_sop, out_eop, out_ready;

  always #4 clk = ~clk;

  svc_stream_cleaner i_svc_stream_cleaner (
    .clk(clk), .rst_n(rst_n),
    .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_ready(out_ready)
  );

  logic [DW-1:0] iq_d[$];
  bit            iq_s[$], iq_e[$];
  logic [DW-1:0] eq_d[$];
  bit            eq_s[$], eq_e[$], eq_pad[$];
  string         eq_tag[$];

  int  n_chk = 0, n_fail = 0;
  int  iidx = 0, gidx = 0;
  int  vld_pct = 100, rdy_pct = 100;
  bit  run = 0;
  bit  m_armed = 0;
  int  m_exp = 0;

  task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_beat();
    logic [127:0] t;
    t = {$urandom, $urandom, $urandom, $urandom};
    return t[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] grey_beat();
    logic [DW-1:0] g;
    for (int i = 0; i < 12; i++) g[i*10 +: 10] = 10'd512;
    return g;
  endfunction

  task automatic push_in(logic [DW-1:0] d, bit s, bit e);
    iq_d.push_back(d); iq_s.push_back(s); iq_e.push_back(e);
  endtask

  task automatic push_exp(logic [DW-1:0] d, bit s, bit e, string tag, bit pad);
    eq_d.push_back(d); eq_s.push_back(s); eq_e.push_back(e);
    eq_tag.push_back(tag); eq_pad.push_back(pad);
  endtask

  task automatic add_ctrl(int w, int h);
    logic [DW-1:0] hd, ds;
    hd = rnd_beat(); hd[3:0] = 4'hF;
    ds = rnd_beat(); ds[15:0] = 16'(w); ds[31:16] = 16'(h);
    push_in(hd, 1, 0); push_exp(hd, 1, 0, "R2", 0);
    push_in(ds, 0, 1); push_exp(ds, 0, 1, "R3", 0);
    m_armed = (w != 0) && (h != 0);
    if (m_armed) m_exp = (w * h + 3) / 4;
  endtask

  task automatic add_user(int n);
    logic [DW-1:0] b;
    b = rnd_beat(); b[3:0] = 4'h5;
    push_in(b, 1, n == 0); push_exp(b, 1, n == 0, "R2", 0);
    for (int i = 0; i < n; i++) begin
      b = rnd_beat();
      push_in(b, 0, i == n - 1); push_exp(b, 0, i == n - 1, "R2", 0);
    end
  endtask

  task automatic add_pix(int n);
    logic [DW-1:0] b;
    string tg;
    tg = (n == 0) ? "R11" : (n == m_exp) ? "R4" : (n < m_exp) ? "R5" : "R7";
    b = rnd_beat(); b[3:0] = 4'h0;
    push_in(b, 1, n == 0);
    if (m_armed) push_exp(b, 1, 0, tg, 0);
    for (int i = 0; i < n; i++) begin
      b = rnd_beat();
      push_in(b, 0, i == n - 1);
      if (m_armed && i < m_exp) push_exp(b, 0, i == m_exp - 1, tg, 0);
    end
    if (m_armed && n < m_exp)
      for (int i = n; i < m_exp; i++) push_exp(grey_beat(), 0, i == m_exp - 1, tg, 1);
    m_armed = 0;
  endtask

  task automatic check_out();
    if (gidx >= eq_d.size()) begin
      chk(0, "R8", "unexpected output beat", out_data, '0);
    end else begin
      chk(out_data == eq_d[gidx] && out_sop == eq_s[gidx] && out_eop == eq_e[gidx],
          eq_tag[gidx], $sformatf("beat %0d sop %0b eop %0b (exp %0b %0b)", gidx,
          out_sop, out_eop, eq_s[gidx], eq_e[gidx]), out_data, eq_d[gidx]);
      if (eq_pad[gidx]) chk(!in_ready, "R6", "in_ready during padding", DW'(in_ready), '0);
    end
    gidx++;
  endtask

  initial begin : drive
    bit in_hs, prev_stall, prev_s, prev_e;
    logic [DW-1:0] prev_d;
    prev_stall = 0; prev_s = 0; prev_e = 0; prev_d = '0;
    wait (run);
    forever begin
      @(negedge clk);
      in_hs = in_valid && in_ready;
      if (prev_stall)
        chk(out_valid && out_data == prev_d && out_sop == prev_s && out_eop == prev_e,
            "R10", "output held under stall", out_data, prev_d);
      if (out_valid && out_ready) check_out();
      prev_stall = out_valid && !out_ready;
      prev_d = out_data; prev_s = out_sop; prev_e = out_eop;
      @(posedge clk); #1;
      if (in_hs) iidx++;
      if (!(in_valid && !in_hs)) begin
        if (iidx < iq_d.size() && ($urandom % 100) < vld_pct) begin
          in_valid = 1; in_data = iq_d[iidx]; in_sop = iq_s[iidx]; in_eop = iq_e[iidx];
        end else begin
          in_valid = 0; in_sop = 0; in_eop = 0;
        end
      end
      out_ready = ($urandom % 100) < rdy_pct;
    end
  end

  task automatic drain();
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (iidx >= iq_d.size() && gidx >= eq_d.size()) break;
    end
    repeat (20) @(posedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(0, "R1", "watchdog expired", '0, '0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(20240611);
    rst_n = 0; in_valid = 0; in_sop = 0; in_eop = 0; in_data = '0; out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R1", "out_valid in reset", DW'(out_valid), '0);
    rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R1", "out_valid after reset", DW'(out_valid), '0);

    // directed corner cases
    add_ctrl(4, 4);  add_pix(4);   // exact
    add_ctrl(3, 3);  add_pix(1);   // 9 px -> 3 beats, short (R3 rounding)
    add_ctrl(5, 2);  add_pix(6);   // 10 px -> 3 beats, long
    add_pix(3);                    // no control: dropped (R8)
    add_ctrl(0, 5);  add_pix(2);   // zero size: dropped (R9)
    add_ctrl(2, 2);  add_pix(0);   // header only (R11)
    add_user(2);
    add_ctrl(1, 1);  add_pix(1);   // one pixel -> one beat
    run = 1;
    drain();
    chk(gidx == eq_d.size(), "R8", "directed output beat count R9",
        DW'(gidx), DW'(eq_d.size()));

    // random phases with varying valid and ready densities
    for (int ph = 0; ph < 3; ph++) begin
      vld_pct = (ph == 0) ? 100 : (ph == 1) ? 60 : 85;
      rdy_pct = (ph == 0) ? 100 : (ph == 1) ? 50 : 30;
      for (int p = 0; p < 25; p++) begin
        int k, w, h, e;
        k = $urandom % 8;
        w = 1 + $urandom % 10; h = 1 + $urandom % 6;
        e = (w * h + 3) / 4;
        if (k == 0)      add_user($urandom % 3);
        else if (k == 1) add_pix($urandom % 4);
        else if (k == 2) begin add_ctrl(w, 0); add_pix($urandom % 4); end
        else begin
          add_ctrl(w, h);
          case ($urandom % 4)
            0: add_pix(e);
            1: add_pix($urandom % e);
            2: add_pix(e + 1 + $urandom % 4);
            default: add_pix(0);
          endcase
        end
      end
      drain();
      chk(gidx == eq_d.size(), "R7", "random phase output beat count R5",
          DW'(gidx), DW'(eq_d.size()));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule